// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block collects up to 63 interrupt request lines and tells the processor which one to serve. It shows the winner as a 3-bit interrupt level plus a 6-bit source number. Each source has a mask bit and an 8-bit control byte. Bits 5:3 of the control byte give the interrupt level and bits 2:0 give the priority inside that level. Bit 0 of the low mask word is not a source mask: it is a global switch that blocks everything while set. Request slot 0 is never a real source. Sources 1 to 7 are external lines whose level is tied to their own number; sources 8 to 63 are fully programmable. Software should give each active source its own level/priority pair, and a control byte of zero marks a source that is not configured.

Software reaches the registers over a simple synchronous word bus with per-byte write enables. Writes commit on the clock edge. Reads are combinational from the word address. The request vector is sampled every cycle. The winner appears on registered outputs one clock later.

Top module: `irqc_top`

## Requirements
- R1: Reset sets both mask words (word 0 holds sources 0..31, word 1 holds sources 32..63) to all ones and clears every stored control byte. While reset is held, `irq_valid`, `irq_level` and `irq_src` are 0. A read of a word outside 0, 1 and 16..31 returns zero.
- R2: The mask bit of source s is bit s[4:0] of mask word s[5]. A 1 blocks the source and a 0 lets it through. Mask words read back exactly as written, one byte at a time under `bus_be`.
- R3: The control byte of source s is lane s%4 (bits 8*(s%4)+7 : 8*(s%4)) of word 16 + s/4. A write changes only the lanes whose `bus_be` bit is set. Bits 7:6 and 2:0 always read back as written.
- R4: For sources 1..7 the level field (bits 5:3) always reads back as the source number, and writes to it are ignored. Their other bits behave as in R3.
- R5: While bit 0 of mask word 0 is 1, `irq_valid` stays 0 whatever the requests are.
- R6: A source is eligible only when its request is high, its mask bit is 0, the global mask bit is 0, and its level field is nonzero. A masked source or a level-0 source never wins.
- R7: Among eligible sources, the one with the highest level wins. Within that level, the highest priority field wins.
- R8: If two eligible sources have equal level and priority, the lower source number wins.
- R9: The outputs show the result for the requests and registers of the previous cycle. With nothing eligible, `irq_valid`, `irq_level` and `irq_src` are all 0.
- R10: A request on slot 0 is never presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, committed at the clock edge |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Per-byte write enables |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | input | 64 | Request lines; slot 0 is unused |
| irq_level | output | 3 | Level of the winning source, 0 when none |
| irq_src | output | 6 | Number of the winning source, 0 when none |
| irq_valid | output | 1 | A winning source is presented |

## Verification
Read data has no delay: the bench sets the address at the falling edge and compares 1 ns later, in the same cycle. A register write commits at the rising edge that follows its falling-edge setup. The arbitration result is due at the first rising edge after the requests are applied. The bench therefore drives each request pattern at a falling edge and compares `irq_valid`, `irq_level` and `irq_src` just after the next rising edge. It computes the expected winner from its own copy of the written registers. Single-cycle pulses followed by an idle pattern check that the result lasts exactly one cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int SLOTS      = 64;
  localparam int SRC_W      = $clog2(SLOTS);
  localparam int LVL_W      = 3;
  localparam int PRI_W      = 3;
  localparam int KEY_W      = LVL_W + PRI_W;
  localparam int FIXED_CNT  = 7;
  localparam int BYTE_W     = 8;
  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / BYTE_W;
  localparam int WADDR_W    = 6;
  localparam int MASK_WORDS = SLOTS / DATA_W;
  localparam int CTRL_BASE  = 16;

  // level field of a priority key
  function automatic logic [LVL_W-1:0] key_level(input logic [KEY_W-1:0] k);
    return k[KEY_W-1:PRI_W];
  endfunction

  // word address holding the control byte of a source
  function automatic logic [WADDR_W-1:0] ctrl_word(input int s);
    return WADDR_W'(CTRL_BASE + s / LANES);
  endfunction

  function automatic bit is_fixed(input int s);
    return (s >= 1) && (s <= FIXED_CNT);
  endfunction
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [WADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [LANES-1:0]       bus_be,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [SLOTS-1:0]       mask_q,
  output logic [SLOTS*KEY_W-1:0] key_flat
);
  logic [BYTE_W-1:0] ctrl_q  [SLOTS];
  logic [BYTE_W-1:0] ctrl_rd [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int s = 0; s < SLOTS; s++) ctrl_q[s] <= '0;
    end else if (bus_we) begin
      for (int w = 0; w < MASK_WORDS; w++)
        if (bus_addr == WADDR_W'(w))
          for (int k = 0; k < LANES; k++)
            if (bus_be[k])
              mask_q[w*DATA_W + k*BYTE_W +: BYTE_W] <= bus_wdata[k*BYTE_W +: BYTE_W];
      for (int s = 0; s < SLOTS; s++)
        if (bus_addr == ctrl_word(s) && bus_be[s % LANES])
          ctrl_q[s] <= bus_wdata[(s % LANES)*BYTE_W +: BYTE_W];
    end
  end

  // fixed external lines: level field tied to the source number
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      if (is_fixed(s))
        ctrl_rd[s] = {ctrl_q[s][BYTE_W-1:KEY_W], LVL_W'(s), ctrl_q[s][PRI_W-1:0]};
      else
        ctrl_rd[s] = ctrl_q[s];
      key_flat[s*KEY_W +: KEY_W] = ctrl_rd[s][KEY_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < MASK_WORDS; w++)
      if (bus_addr == WADDR_W'(w)) bus_rdata = mask_q[w*DATA_W +: DATA_W];
    for (int s = 0; s < SLOTS; s++)
      if (bus_addr == ctrl_word(s))
        bus_rdata[(s % LANES)*BYTE_W +: BYTE_W] = ctrl_rd[s];
  end
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [SLOTS-1:0]       elig,
  input  logic [SLOTS*KEY_W-1:0] key_flat,
  output logic                   found,
  output logic [SRC_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_level
);
  logic [KEY_W-1:0] best;

  // scan downward; ">=" lets a lower index take over an equal key
  always_comb begin
    found   = 1'b0;
    best    = '0;
    win_idx = '0;
    for (int s = SLOTS-1; s >= 0; s--) begin
      if (elig[s] && (!found || key_flat[s*KEY_W +: KEY_W] >= best)) begin
        found   = 1'b1;
        best    = key_flat[s*KEY_W +: KEY_W];
        win_idx = SRC_W'(s);
      end
    end
    win_level = key_level(best);
  end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [WADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [LANES-1:0]   bus_be,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [SLOTS-1:0]   irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [SRC_W-1:0]   irq_src,
  output logic               irq_valid
);
  logic [SLOTS-1:0]       mask_q;
  logic [SLOTS*KEY_W-1:0] key_flat;
  logic                   mask_all;
  logic [SLOTS-1:0]       elig;
  logic                   found;
  logic [SRC_W-1:0]       win_idx;
  logic [LVL_W-1:0]       win_level;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .mask_q(mask_q), .key_flat(key_flat)
  );

  assign mask_all = mask_q[0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_elig
    if (s == 0) begin : g_unused
      assign elig[s] = irq_req[s] & 1'b0;
    end else begin : g_src
      assign elig[s] = irq_req[s] & ~mask_q[s] & ~mask_all &
                       (key_level(key_flat[s*KEY_W +: KEY_W]) != '0);
    end
  end

  irqc_arbiter u_arb (
    .elig(elig), .key_flat(key_flat),
    .found(found), .win_idx(win_idx), .win_level(win_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_valid <= found;
      irq_level <= found ? win_level : '0;
      irq_src   <= found ? win_idx : '0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
  import irqc_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [SLOTS-1:0]       elig,
  input logic [SLOTS*KEY_W-1:0] key_flat,
  input logic                   mask_all,
  input logic                   found,
  input logic [SRC_W-1:0]       win_idx,
  input logic [LVL_W-1:0]       win_level,
  input logic [WADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic                   irq_valid,
  input logic [LVL_W-1:0]       irq_level,
  input logic [SRC_W-1:0]       irq_src
);
  logic [SLOTS-1:0] elig_d;
  logic             beaten;
  logic [KEY_W-1:0] wkey;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) elig_d <= '0;
    else        elig_d <= elig;

  // independent search for any eligible source that should have won
  always_comb begin
    wkey   = key_flat[win_idx*KEY_W +: KEY_W];
    beaten = 1'b0;
    for (int s = 1; s < SLOTS; s++)
      if (elig[s] && ((key_flat[s*KEY_W +: KEY_W] > wkey) ||
          (key_flat[s*KEY_W +: KEY_W] == wkey && SRC_W'(s) < win_idx)))
        beaten = 1'b1;
  end

  a_r5_mask_all_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> !irq_valid);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> irq_valid && irq_level == $past(win_level) && irq_src == $past(win_idx));
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !found |=> !irq_valid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_level == '0 && irq_src == '0);
  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> elig_d[irq_src] && irq_level != '0);
  a_r7_no_better_source: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !beaten);  // R8 tie order also covered by beaten
  a_r10_slot0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_src != '0);
  a_r4_fixed_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == WADDR_W'(CTRL_BASE)) |->
      bus_rdata[13:11] == 3'd1 && bus_rdata[21:19] == 3'd2 && bus_rdata[29:27] == 3'd3);
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .elig(elig), .key_flat(key_flat),
  .mask_all(mask_all), .found(found), .win_idx(win_idx), .win_level(win_level),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_valid(irq_valid), .irq_level(irq_level), .irq_src(irq_src)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_req = '0;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;
  logic        irq_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] sh_mask;
  logic [7:0]  sh_ctrl [64];

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .irq_src(irq_src), .irq_valid(irq_valid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // effective control byte per the requirements (R4 fixed levels)
  function automatic logic [7:0] effc(input int s);
    logic [7:0] c = sh_ctrl[s];
    if (s >= 1 && s <= 7) c[5:3] = 3'(s);
    return c;
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] d = '0;
    if (w < 2) d = sh_mask[w*32 +: 32];
    else if (w >= 16 && w < 32)
      for (int k = 0; k < 4; k++) d[k*8 +: 8] = effc((w-16)*4 + k);
    return d;
  endfunction

  // expected {valid, level, src}: ascending scan, strict compare keeps lower index
  function automatic logic [9:0] model(input logic [63:0] r);
    bit f = 0;
    logic [5:0] best = '0;
    int bi = 0;
    for (int s = 1; s < 64; s++) begin
      logic [7:0] c = effc(s);
      if (r[s] && !sh_mask[s] && !sh_mask[0] && c[5:3] != 3'd0)
        if (!f || c[5:0] > best) begin f = 1; best = c[5:0]; bi = s; end
    end
    return f ? {1'b1, best[5:3], 6'(bi)} : 10'd0;
  endfunction

  task automatic wr(input int w, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'(w); bus_wdata = d; bus_be = be;
    @(posedge clk);
    for (int k = 0; k < 4; k++) if (be[k]) begin
      if (w < 2) sh_mask[w*32 + k*8 +: 8] = d[k*8 +: 8];
      else if (w >= 16 && w < 32) sh_ctrl[(w-16)*4 + k] = d[k*8 +: 8];
    end
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input int w, input string tag);
    @(negedge clk);
    bus_addr = 6'(w);
    #1;
    chk(tag, {32'd0, bus_rdata}, {32'd0, exp_word(w)});
  endtask

  task automatic apply(input logic [63:0] r, input string tag);
    @(negedge clk);
    irq_req = r;
    @(posedge clk);
    #1;
    chk(tag, {54'd0, irq_valid, irq_level, irq_src}, {54'd0, model(r)});
  endtask

  function automatic logic [7:0] prog(input int s);
    int m;
    if (s == 0) return 8'h3F;
    if (s < 8)  return 8'h78 | 8'(7 - s);   // level bits must be ignored
    if (s == 9) return 8'h00;               // unconfigured
    if (s == 50) s = 40;                    // duplicate key for tie test
    m = ((s - 8) * 13) % 56;
    return {2'b10, 3'(m / 8 + 1), 3'(m % 8)};
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] st;
    sh_mask = '1;
    for (int s = 0; s < 64; s++) sh_ctrl[s] = 8'h00;
    irq_req = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs in reset", {54'd0, irq_valid, irq_level, irq_src}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R4 reset readback
    rd(0, "R1 mask lo"); rd(1, "R1 mask hi"); rd(5, "R1 unmapped");
    for (int w = 16; w < 32; w++) rd(w, "R1 R4 ctrl reset");
    apply('1, "R5 reset mask-all");

    // R3 program all control bytes
    for (int w = 16; w < 32; w++)
      wr(w, {prog((w-16)*4+3), prog((w-16)*4+2), prog((w-16)*4+1), prog((w-16)*4)}, 4'hF);
    for (int w = 16; w < 32; w++) rd(w, "R3 R4 ctrl readback");
    wr(20, 32'hA5A5_A5A5, 4'b0100);
    rd(19, "R3 neighbour below"); rd(20, "R3 single lane"); rd(21, "R3 neighbour above");
    wr(16, 32'h0000_0000, 4'b1110);
    rd(16, "R4 fixed level write ignored");
    wr(16, {prog(3), prog(2), prog(1), prog(0)}, 4'hF);

    // R2 / R5 unmask everything except the global bit
    wr(1, 32'h0000_0000, 4'hF);
    wr(0, 32'h0000_0001, 4'hF);
    rd(0, "R2 mask lo"); rd(1, "R2 mask hi");
    apply('1, "R5 mask-all still set");
    wr(0, 32'h0000_0000, 4'b0001);
    rd(0, "R2 mask lo cleared");

    // single-source sweep
    for (int s = 0; s < 64; s++)
      apply(64'd1 << s, s == 0 ? "R10 slot0" : s == 9 ? "R6 level zero" :
                        s < 8 ? "R4 fixed source" : "R7 single");
    apply((64'd1 << 40) | (64'd1 << 50), "R8 tie lower index");
    apply((64'd1 << 50) | (64'd1 << 9), "R6 R8 tie partner alone");
    apply(64'd1 << 33, "R9 pulse");
    apply(64'd0, "R9 idle after pulse");

    // random sweep, all unmasked
    st = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 400; i++) begin
      st ^= st << 13; st ^= st >> 7; st ^= st << 17;
      apply((i % 2 == 0) ? (st & (st >> 5) & (st >> 11)) : st, "R7 random");
    end

    // partial masking
    wr(1, 32'hF0F0_0F0F, 4'hF);
    wr(0, 32'h00FF_AA54, 4'b0111);
    rd(0, "R2 mask lo partial"); rd(1, "R2 mask hi partial");
    for (int i = 0; i < 300; i++) begin
      st ^= st << 13; st ^= st >> 7; st ^= st << 17;
      apply((i % 3 == 0) ? (st & (st >> 9)) : st, "R6 masked random");
    end

    // global mask reasserted
    wr(0, 32'h0000_0001, 4'b0001);
    apply('1, "R5 mask-all reasserted");
    apply(64'h8000_0000_0000_0002, "R5 mask-all sparse");
    wr(0, 32'h0000_0000, 4'b0001);
    apply(64'h0000_0000_0000_0004, "R9 after mask-all cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule